// File: doc/BRIEF.md
# UART Receive-Side Software Flow-Control Detector

This block sits between a UART receiver and the receive FIFO. Every character the receiver strobes in is compared against four programmable flow characters: two resume characters and two pause characters. The comparison uses only as many bits as the configured word length. In single-character mode one received character triggers an action. In two-character mode the action needs a first and a second character in consecutive order. Matched flow characters are consumed and never reach the FIFO. All other characters are forwarded, with the bits above the word length cleared.

A pause match makes the block suspend the local transmitter. The pause request rises only at a character boundary: when the transmitter reports that a character has finished, or when it is idle. A resume match lifts the pause and clears the status flag. The status flag is also set by an optional special-character detector, which watches for the second pause character, lets it through to the FIFO and sets the same flag. The interrupt request is the status flag gated by an interrupt enable. Software can also clear the flag with a strobe.

Received-character strobes must be at least two clock cycles apart. This always holds for a serial receiver, and it gives the block the spare cycle it needs to forward two held characters.

Top module: `fc_rx_flow_detect`

## Requirements
- R1: In off mode (`fc_mode`=00, with 11 treated the same), or when a character matches nothing, the character appears on `fifo_data` with `fifo_we` high on the clock edge that follows its `rx_valid` cycle.
- R2: In single mode (`fc_mode`=01), a character equal to pause-1 suspends the transmitter and a character equal to resume-1 resumes it. Neither is written to the FIFO. If both registers match, the pause action wins.
- R3: In two-character mode (`fc_mode`=10), pause-1 followed by pause-2 suspends the transmitter, and resume-1 followed by resume-2 resumes it. Neither character of a completed pair is written to the FIFO.
- R4: In two-character mode, if a held first character is followed by a non-matching character, both are written to the FIFO in arrival order on consecutive cycles, and matching restarts from the next character.
- R5: `tx_pause` is only high while the transmitter is suspended. It rises only one edge after `tx_char_done` was high or `tx_busy` was low.
- R6: A completed resume match drops `tx_pause` and clears `fc_flag` on the next edge.
- R7: A completed pause match sets `fc_flag` on the next edge. `irq` equals `fc_flag` AND `irq_en`.
- R8: The four character registers reset to zero. They are written through `cfg_we`/`cfg_sel`/`cfg_wdata`, with select 0 = resume-1, 1 = resume-2, 2 = pause-1 and 3 = pause-2.
- R9: With `spec_en` high, a forwarded character equal to pause-2 is still written to the FIFO and sets `fc_flag`. It does not suspend the transmitter.
- R10: When a character completes a two-character pause pair and also matches pause-2 as a special character, the pair match wins: nothing is written and the transmitter is suspended.
- R11: `word_len` 00/01/10/11 selects 5/6/7/8 compared bits, counted from bit 0. Characters written to the FIFO have the unused upper bits cleared.
- R12: `flag_clr` clears `fc_flag` on the next edge. A flag-setting event in the same cycle takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Character register write strobe |
| cfg_sel | input | 2 | Register select: 0 resume-1, 1 resume-2, 2 pause-1, 3 pause-2 |
| cfg_wdata | input | DATA_W | Register write data |
| fc_mode | input | 2 | 00 off, 01 single, 10 two-character, 11 off |
| word_len | input | 2 | Compared bits: 00=5, 01=6, 10=7, 11=8 |
| spec_en | input | 1 | Special-character detect enable |
| irq_en | input | 1 | Interrupt enable for the status flag |
| flag_clr | input | 1 | Software clear of the status flag |
| rx_valid | input | 1 | Received-character strobe |
| rx_data | input | DATA_W | Received character, bit 0 first received |
| tx_busy | input | 1 | Transmitter is shifting a character |
| tx_char_done | input | 1 | Transmitter finished a character |
| fifo_we | output | 1 | Receive FIFO write strobe |
| fifo_data | output | DATA_W | Character to the receive FIFO |
| tx_pause | output | 1 | Pause request to the transmitter |
| fc_flag | output | 1 | Flow-control / special-character status |
| irq | output | 1 | Interrupt request |

## Verification
The hardest state to reach from the ports is a held first character meeting a second character that fails the pair, because it produces two FIFO writes from a single strobe. The stimulus reaches it by sending pause-1 and then an unrelated byte, and checks the order of the two writes. A second hard case is the overlap between a completed two-character pause and special detection on the same pause-2 value. It is reached with `spec_en` high during a pair. The pause boundary rule is exercised by holding `tx_busy` high through a pause match and releasing it with a lone `tx_char_done` pulse.

// File: rtl/fc_pkg.sv
package fc_pkg;
    localparam int unsigned LEN_W  = 2;
    localparam int unsigned N_CHAR = 4;

    typedef enum logic [1:0] {
        FC_OFF    = 2'd0,
        FC_SINGLE = 2'd1,
        FC_DOUBLE = 2'd2,
        FC_RSVD   = 2'd3
    } fc_mode_e;

    // register select / hit vector index
    localparam int unsigned IDX_ON1  = 0;
    localparam int unsigned IDX_ON2  = 1;
    localparam int unsigned IDX_OFF1 = 2;
    localparam int unsigned IDX_OFF2 = 3;
endpackage

// File: rtl/fc_char_regs.sv
module fc_char_regs
    import fc_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we,
    input  logic [$clog2(N_CHAR)-1:0]     sel,
    input  logic [DATA_W-1:0]             wdata,
    output logic [N_CHAR-1:0][DATA_W-1:0] chars
);
    typedef struct packed {
        logic [N_CHAR-1:0][DATA_W-1:0] chr;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            st_d.chr[sel] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign chars = st_q.chr;
endmodule

// File: rtl/fc_char_cmp.sv
module fc_char_cmp
    import fc_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic [DATA_W-1:0]             rx_data,
    input  logic [LEN_W-1:0]              word_len,
    input  logic [N_CHAR-1:0][DATA_W-1:0] chars,
    output logic [DATA_W-1:0]             rx_masked,
    output logic [N_CHAR-1:0]             hit
);
    localparam int MIN_W = int'(DATA_W) - (1 << LEN_W) + 1;

    logic [DATA_W-1:0] mask;

    always_comb begin
        for (int i = 0; i < int'(DATA_W); i++) begin
            mask[i] = (i < MIN_W + int'(word_len));
        end
    end

    assign rx_masked = rx_data & mask;

    for (genvar g = 0; g < N_CHAR; g++) begin : g_hit
        assign hit[g] = ((chars[g] & mask) == rx_masked);
    end
endmodule

// File: rtl/fc_pause_ctrl.sv
module fc_pause_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic suspend_next,
    input  logic suspend_q,
    input  logic tx_busy,
    input  logic tx_char_done,
    output logic tx_pause
);
    typedef struct packed {
        logic pause;
    } pause_t;

    pause_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!suspend_next) begin
            st_d.pause = 1'b0;
        end else if (tx_char_done || !tx_busy) begin
            st_d.pause = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tx_pause = st_q.pause;

    assert_pause_needs_suspend_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pause |-> suspend_q);

    assert_pause_at_boundary_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_pause) |-> $past(tx_char_done || !tx_busy));
endmodule

// File: rtl/fc_rx_flow_detect.sv
module fc_rx_flow_detect
    import fc_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic [1:0]        fc_mode,
    input  logic [1:0]        word_len,
    input  logic              spec_en,
    input  logic              irq_en,
    input  logic              flag_clr,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              tx_busy,
    input  logic              tx_char_done,
    output logic              fifo_we,
    output logic [DATA_W-1:0] fifo_data,
    output logic              tx_pause,
    output logic              fc_flag,
    output logic              irq
);
    typedef struct packed {
        logic              held;
        logic              held_off;
        logic              held_on;
        logic [DATA_W-1:0] held_data;
        logic              pend;
        logic [DATA_W-1:0] pend_data;
        logic              fifo_we;
        logic [DATA_W-1:0] fifo_data;
        logic              suspend;
        logic              flag;
    } det_t;

    det_t st_d, st_q;

    logic [N_CHAR-1:0][DATA_W-1:0] chars;
    logic [DATA_W-1:0]             rx_m;
    logic [N_CHAR-1:0]             hit;
    fc_mode_e                      mode;
    logic                          xoff_evt, xon_evt, spec_evt, pass_chr;

    assign mode = fc_mode_e'(fc_mode);

    fc_char_regs #(.DATA_W(DATA_W)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .sel   (cfg_sel),
        .wdata (cfg_wdata),
        .chars (chars)
    );

    fc_char_cmp #(.DATA_W(DATA_W)) u_cmp (
        .rx_data   (rx_data),
        .word_len  (word_len),
        .chars     (chars),
        .rx_masked (rx_m),
        .hit       (hit)
    );

    always_comb begin
        st_d         = st_q;
        st_d.fifo_we = 1'b0;
        xoff_evt     = 1'b0;
        xon_evt      = 1'b0;
        spec_evt     = 1'b0;
        pass_chr     = 1'b0;

        // second write of a flushed pair
        if (st_q.pend) begin
            st_d.fifo_we   = 1'b1;
            st_d.fifo_data = st_q.pend_data;
            st_d.pend      = 1'b0;
        end

        if (mode != FC_DOUBLE) begin
            st_d.held = 1'b0;
        end

        if (rx_valid) begin
            unique case (mode)
                FC_SINGLE: begin
                    if (hit[IDX_OFF1]) begin
                        xoff_evt = 1'b1;
                    end else if (hit[IDX_ON1]) begin
                        xon_evt = 1'b1;
                    end else begin
                        pass_chr = 1'b1;
                    end
                end
                FC_DOUBLE: begin
                    if (st_q.held) begin
                        st_d.held = 1'b0;
                        if (st_q.held_off && hit[IDX_OFF2]) begin
                            xoff_evt = 1'b1;
                        end else if (st_q.held_on && hit[IDX_ON2]) begin
                            xon_evt = 1'b1;
                        end else begin
                            st_d.fifo_we   = 1'b1;
                            st_d.fifo_data = st_q.held_data;
                            st_d.pend      = 1'b1;
                            st_d.pend_data = rx_m;
                            spec_evt       = spec_en && hit[IDX_OFF2];
                        end
                    end else if (hit[IDX_OFF1] || hit[IDX_ON1]) begin
                        st_d.held      = 1'b1;
                        st_d.held_off  = hit[IDX_OFF1];
                        st_d.held_on   = hit[IDX_ON1];
                        st_d.held_data = rx_m;
                    end else begin
                        pass_chr = 1'b1;
                    end
                end
                default: begin
                    pass_chr = 1'b1;
                end
            endcase

            if (pass_chr) begin
                st_d.fifo_we   = 1'b1;
                st_d.fifo_data = rx_m;
                spec_evt       = spec_en && hit[IDX_OFF2];
            end
        end

        if (xoff_evt) begin
            st_d.suspend = 1'b1;
        end else if (xon_evt) begin
            st_d.suspend = 1'b0;
        end

        if (xoff_evt || spec_evt) begin
            st_d.flag = 1'b1;
        end else if (xon_evt || flag_clr) begin
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    fc_pause_ctrl u_pause (
        .clk          (clk),
        .rst_n        (rst_n),
        .suspend_next (st_d.suspend),
        .suspend_q    (st_q.suspend),
        .tx_busy      (tx_busy),
        .tx_char_done (tx_char_done),
        .tx_pause     (tx_pause)
    );

    assign fifo_we   = st_q.fifo_we;
    assign fifo_data = st_q.fifo_data;
    assign fc_flag   = st_q.flag;
    assign irq       = st_q.flag & irq_en;

    assert_off_mode_forwards_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && (mode == FC_OFF) && !st_q.pend) |=>
            (fifo_we && (fifo_data == $past(rx_m))));

    assert_single_swallow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && (mode == FC_SINGLE) && (hit[IDX_OFF1] || hit[IDX_ON1]) && !st_q.pend)
            |=> !fifo_we);

    assert_pair_pause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && (mode == FC_DOUBLE) && st_q.held && st_q.held_off && hit[IDX_OFF2])
            |=> (st_q.suspend && !fifo_we));

    assert_flush_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && (mode == FC_DOUBLE) && st_q.held
            && !(st_q.held_off && hit[IDX_OFF2]) && !(st_q.held_on && hit[IDX_ON2]))
            |=> (fifo_we && (fifo_data == $past(st_q.held_data))));

    assert_resume_drops_pause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (xon_evt && !xoff_evt) |=> (!tx_pause && !fc_flag));

    assert_pause_sets_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        xoff_evt |=> fc_flag);

    assert_pair_beats_special_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && spec_en && (mode == FC_DOUBLE) && st_q.held && st_q.held_off
            && hit[IDX_OFF2]) |=> !fifo_we);
endmodule

// File: tb/tb_fc_rx_flow_detect.sv
`timescale 1ns/1ps
module tb_fc_rx_flow_detect;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_sel = '0;
    logic [7:0] cfg_wdata = '0;
    logic [1:0] fc_mode = '0;
    logic [1:0] word_len = 2'd3;
    logic       spec_en = 1'b0;
    logic       irq_en = 1'b0;
    logic       flag_clr = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = '0;
    logic       tx_busy = 1'b0;
    logic       tx_char_done = 1'b0;
    logic       fifo_we;
    logic [7:0] fifo_data;
    logic       tx_pause;
    logic       fc_flag;
    logic       irq;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] wlog [256];
    int log_n = 0;

    always #2.5 clk = ~clk;

    fc_rx_flow_detect #(.DATA_W(8)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .fc_mode(fc_mode), .word_len(word_len),
        .spec_en(spec_en), .irq_en(irq_en), .flag_clr(flag_clr),
        .rx_valid(rx_valid), .rx_data(rx_data), .tx_busy(tx_busy),
        .tx_char_done(tx_char_done), .fifo_we(fifo_we), .fifo_data(fifo_data),
        .tx_pause(tx_pause), .fc_flag(fc_flag), .irq(irq)
    );

    always @(negedge clk) begin
        if (fifo_we) begin
            wlog[log_n[7:0]] = fifo_data;
            log_n = log_n + 1;
        end
    end

    typedef struct packed {
        logic [3:0] req;
        logic [1:0] mode;
        logic [1:0] wl;
        logic       spec;
        logic       clr;
        logic [7:0] data;
        logic [1:0] nwr;
        logic [7:0] first;
        logic [7:0] last;
        logic       flag;
        logic       pause;
    } vec_t;

    // registers: resume-1=11 resume-2=22 pause-1=93 pause-2=44
    localparam int NV = 24;
    localparam vec_t VECS [NV] = '{
        '{4'd1,  2'd1, 2'd3, 1'b0, 1'b0, 8'h41, 2'd1, 8'h41, 8'h41, 1'b0, 1'b0}, // R1
        '{4'd2,  2'd1, 2'd3, 1'b0, 1'b0, 8'h93, 2'd0, 8'h00, 8'h00, 1'b1, 1'b1}, // R2
        '{4'd1,  2'd1, 2'd3, 1'b0, 1'b0, 8'h55, 2'd1, 8'h55, 8'h55, 1'b1, 1'b1}, // R1
        '{4'd6,  2'd1, 2'd3, 1'b0, 1'b0, 8'h11, 2'd0, 8'h00, 8'h00, 1'b0, 1'b0}, // R6
        '{4'd11, 2'd1, 2'd0, 1'b0, 1'b0, 8'h13, 2'd0, 8'h00, 8'h00, 1'b1, 1'b1}, // R11
        '{4'd11, 2'd1, 2'd0, 1'b0, 1'b0, 8'hF1, 2'd0, 8'h00, 8'h00, 1'b0, 1'b0}, // R11
        '{4'd11, 2'd1, 2'd3, 1'b0, 1'b0, 8'h13, 2'd1, 8'h13, 8'h13, 1'b0, 1'b0}, // R11
        '{4'd3,  2'd2, 2'd3, 1'b0, 1'b0, 8'h93, 2'd0, 8'h00, 8'h00, 1'b0, 1'b0}, // R3
        '{4'd3,  2'd2, 2'd3, 1'b0, 1'b0, 8'h44, 2'd0, 8'h00, 8'h00, 1'b1, 1'b1}, // R3
        '{4'd3,  2'd2, 2'd3, 1'b0, 1'b0, 8'h11, 2'd0, 8'h00, 8'h00, 1'b1, 1'b1}, // R3
        '{4'd3,  2'd2, 2'd3, 1'b0, 1'b0, 8'h22, 2'd0, 8'h00, 8'h00, 1'b0, 1'b0}, // R3
        '{4'd4,  2'd2, 2'd3, 1'b0, 1'b0, 8'h93, 2'd0, 8'h00, 8'h00, 1'b0, 1'b0}, // R4
        '{4'd4,  2'd2, 2'd3, 1'b0, 1'b0, 8'h50, 2'd2, 8'h93, 8'h50, 1'b0, 1'b0}, // R4
        '{4'd1,  2'd0, 2'd3, 1'b0, 1'b0, 8'h93, 2'd1, 8'h93, 8'h93, 1'b0, 1'b0}, // R1
        '{4'd9,  2'd0, 2'd3, 1'b1, 1'b0, 8'h44, 2'd1, 8'h44, 8'h44, 1'b1, 1'b0}, // R9
        '{4'd12, 2'd0, 2'd3, 1'b0, 1'b1, 8'h60, 2'd1, 8'h60, 8'h60, 1'b0, 1'b0}, // R12
        '{4'd10, 2'd2, 2'd3, 1'b1, 1'b0, 8'h93, 2'd0, 8'h00, 8'h00, 1'b0, 1'b0}, // R10
        '{4'd10, 2'd2, 2'd3, 1'b1, 1'b0, 8'h44, 2'd0, 8'h00, 8'h00, 1'b1, 1'b1}, // R10
        '{4'd12, 2'd2, 2'd3, 1'b1, 1'b1, 8'h11, 2'd0, 8'h00, 8'h00, 1'b0, 1'b1}, // R12
        '{4'd6,  2'd2, 2'd3, 1'b1, 1'b0, 8'h22, 2'd0, 8'h00, 8'h00, 1'b0, 1'b0}, // R6
        '{4'd11, 2'd1, 2'd1, 1'b0, 1'b0, 8'hD3, 2'd0, 8'h00, 8'h00, 1'b1, 1'b1}, // R11
        '{4'd11, 2'd1, 2'd1, 1'b0, 1'b0, 8'hC5, 2'd1, 8'h05, 8'h05, 1'b1, 1'b1}, // R11
        '{4'd6,  2'd1, 2'd3, 1'b0, 1'b0, 8'h11, 2'd0, 8'h00, 8'h00, 1'b0, 1'b0}, // R6
        '{4'd11, 2'd1, 2'd2, 1'b0, 1'b0, 8'hE2, 2'd1, 8'h62, 8'h62, 1'b0, 1'b0}  // R11
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic cfg_write(input logic [1:0] sel, input logic [7:0] val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic send(input logic [7:0] d);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = d;
        @(negedge clk);
        rx_valid = 1'b0;
        settle(2);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        int base;
        repeat (3) @(negedge clk);
        #1;
        check("R1", "fifo_we in reset", {31'd0, fifo_we}, 32'd0);
        check("R5", "tx_pause in reset", {31'd0, tx_pause}, 32'd0);
        check("R7", "flag in reset", {31'd0, fc_flag}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R8: registers are zero after reset, so 00 is a pause match (pause wins)
        fc_mode = 2'd1;
        base = log_n;
        send(8'h00);
        check("R8", "writes for zero char", log_n - base, 32'd0);
        check("R8", "flag after zero pause", {31'd0, fc_flag}, 32'd1);
        check("R7", "irq gated off", {31'd0, irq}, 32'd0);
        irq_en = 1'b1;
        #1;
        check("R7", "irq enabled", {31'd0, irq}, 32'd1);

        cfg_write(2'd0, 8'h11);
        cfg_write(2'd1, 8'h22);
        cfg_write(2'd2, 8'h93);
        cfg_write(2'd3, 8'h44);
        send(8'h11);
        check("R8", "resume via written reg", {31'd0, tx_pause}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            string rq;
            rq = $sformatf("R%0d vec%0d", VECS[i].req, i);
            @(negedge clk);
            fc_mode = VECS[i].mode; word_len = VECS[i].wl; spec_en = VECS[i].spec;
            if (VECS[i].clr) begin
                flag_clr = 1'b1;
                @(negedge clk);
                flag_clr = 1'b0;
            end
            base = log_n;
            send(VECS[i].data);
            check(rq, "write count", log_n - base, {30'd0, VECS[i].nwr});
            if (VECS[i].nwr != 2'd0) begin
                check(rq, "first write", {24'd0, wlog[base[7:0]]}, {24'd0, VECS[i].first});
                check(rq, "last write", {24'd0, wlog[8'(log_n - 1)]}, {24'd0, VECS[i].last});
            end
            check(rq, "flag", {31'd0, fc_flag}, {31'd0, VECS[i].flag});
            check(rq, "pause", {31'd0, tx_pause}, {31'd0, VECS[i].pause});
        end

        // R5: pause waits for the transmitter's character boundary
        fc_mode = 2'd1; word_len = 2'd3; spec_en = 1'b0;
        tx_busy = 1'b1;
        send(8'h93);
        check("R5", "no pause mid-character", {31'd0, tx_pause}, 32'd0);
        check("R7", "flag while busy", {31'd0, fc_flag}, 32'd1);
        @(negedge clk);
        tx_char_done = 1'b1;
        @(negedge clk);
        tx_char_done = 1'b0;
        #1;
        check("R5", "pause after done", {31'd0, tx_pause}, 32'd1);
        tx_busy = 1'b0;
        send(8'h11);
        check("R6", "resume from busy pause", {31'd0, tx_pause}, 32'd0);

        // R12: set wins over clear in the same cycle
        @(negedge clk);
        rx_valid = 1'b1; rx_data = 8'h93; flag_clr = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0; flag_clr = 1'b0;
        #1;
        check("R12", "set beats clear", {31'd0, fc_flag}, 32'd1);
        send(8'h11);
        check("R6", "flag cleared by resume", {31'd0, fc_flag}, 32'd0);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule